// File: doc/BRIEF.md
# Receive Frame Error Statistics Pulser

This block sits on the receive side of a wide media-independent interface. Each byte lane carries a control flag. The block follows every frame from its start code to its terminate code and counts the data bytes in between. When a frame closes, it reads the frame check sequence verdict, which a separate CRC stage supplies. It then raises single-cycle increment strobes that external statistics counters add up.

Four strobes are produced:

- A general FCS-error strobe, for any frame that fails its check.
- A short-frame strobe, for a frame below the minimum length that also fails its check.
- An oversize strobe, for a frame above the maximum length that also fails its check.
- A legal-size FCS-error strobe, for a frame within the size limits that fails its check.

The strobes are raised as soon as the frame ends on the line. They do not depend on whether the frame is later delivered to a client or filtered out.

The incoming stream is assumed to close at most one frame per word. Any number of lanes is supported, and lane 0 always holds the earliest byte.

Top module: `rx_err_stats`

## Requirements
- R1: While reset is asserted, and after it is released, all four strobes are low and no frame is open. A terminate code that arrives before any start code produces no strobe.
- R2: A lane with its control flag clear carries a data byte. A lane with its flag set and value 0x07 is idle, 0xFB opens a frame, and 0xFD terminates it. Lanes are processed from lane 0 (earliest) upward.
- R3: A frame's length is the number of data lanes between its start code and its terminate code, minus PRE_LEN (default 7 preamble and delimiter bytes). FCS bytes are included in the length. The running count saturates instead of wrapping.
- R4: `inc_fcs_err` is high for exactly one cycle, in the cycle after the word holding the terminate code, whenever `rx_fcs_bad` is high in that word. This holds for any frame length.
- R5: `inc_runt` pulses together with `inc_fcs_err` when the failing frame's length is below MIN_LEN (default 64).
- R6: `inc_giant` pulses together with `inc_fcs_err` when the failing frame's length exceeds MAX_LEN (default 1518).
- R7: `inc_sized_fcs_err` pulses together with `inc_fcs_err` when the failing frame's length is between MIN_LEN and MAX_LEN inclusive.
- R8: A frame whose FCS check passes produces no strobe at all, whatever its length.
- R9: A start code that arrives while a frame is open closes the old frame as an FCS-error frame, classified by the length it had reached. Counting then restarts for the new frame.
- R10: A terminate code with no open frame is ignored. `rx_fcs_bad` has no effect in any word that does not close a frame.
- R11: At most one of `inc_runt`, `inc_giant` and `inc_sized_fcs_err` is high in any cycle. Each of them is high only together with `inc_fcs_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 8*LANES | Receive bytes; lane i in bits 8i+7:8i |
| rx_ctrl | input | LANES | Per-lane control flag |
| rx_fcs_bad | input | 1 | FCS check failed; read in the word holding the terminate code |
| inc_fcs_err | output | 1 | Increment: frame with FCS error |
| inc_runt | output | 1 | Increment: short frame with FCS error |
| inc_giant | output | 1 | Increment: oversize frame with FCS error |
| inc_sized_fcs_err | output | 1 | Increment: legal-size frame with FCS error |

## Verification
The assertions check the following on every cycle:

- The size strobes are mutually exclusive.
- Every size strobe is accompanied by the general strobe.
- Every general strobe carries exactly one size class and follows a frame-close event.
- A passing frame close is followed by silence.
- An abort close needs a start code in the same word.
- Words without start or terminate codes close nothing.

Only the bench scenarios can show the rest:

- That the byte count is right at the boundaries 63/64 and 1518/1519.
- That the count saturates on very long frames.
- That an interrupted frame is classified by its partial length.
- That a stray terminate code, or a stray FCS flag, leaves the counters untouched.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

  localparam logic [7:0] CODE_IDLE  = 8'h07;
  localparam logic [7:0] CODE_START = 8'hFB;
  localparam logic [7:0] CODE_TERM  = 8'hFD;

  typedef struct packed {
    logic fcs;
    logic runt;
    logic giant;
    logic sized;
  } err_pulse_t;

  // raw lane count minus preamble/delimiter, floored at zero
  function automatic int unsigned payload_len(input int unsigned raw,
                                              input int unsigned pre);
    return (raw > pre) ? raw - pre : 0;
  endfunction

  function automatic err_pulse_t classify(input int unsigned len,
                                          input logic        bad,
                                          input int unsigned min_len,
                                          input int unsigned max_len);
    err_pulse_t p;
    p.fcs   = bad;
    p.runt  = bad && (len < min_len);
    p.giant = bad && (len > max_len);
    p.sized = bad && (len >= min_len) && (len <= max_len);
    return p;
  endfunction

endpackage

// File: rtl/rxerr_lane_decode.sv
module rxerr_lane_decode #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] word_i,
  input  logic [LANES-1:0]   ctrl_i,
  output logic [LANES-1:0]   is_data_o,
  output logic [LANES-1:0]   is_start_o,
  output logic [LANES-1:0]   is_term_o
);
  import rxerr_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_v;
    assign byte_v        = word_i[g*8 +: 8];
    assign is_data_o[g]  = !ctrl_i[g];
    assign is_start_o[g] = ctrl_i[g] && (byte_v == CODE_START);
    assign is_term_o[g]  = ctrl_i[g] && (byte_v == CODE_TERM);
  end

endmodule

// File: rtl/rxerr_frame_track.sv
module rxerr_frame_track #(
  parameter int LANES = 4,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] is_data_i,
  input  logic [LANES-1:0] is_start_i,
  input  logic [LANES-1:0] is_term_i,
  output logic             close_evt_o,
  output logic             close_abort_o,
  output logic [CNT_W-1:0] close_cnt_o
);

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // scan lanes earliest first; the first close in a word is reported
  always_comb begin
    open_d        = open_q;
    cnt_d         = cnt_q;
    close_evt_o   = 1'b0;
    close_abort_o = 1'b0;
    close_cnt_o   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (is_start_i[i]) begin
        if (open_d && !close_evt_o) begin
          close_evt_o   = 1'b1;
          close_abort_o = 1'b1;
          close_cnt_o   = cnt_d;
        end
        open_d = 1'b1;
        cnt_d  = '0;
      end else if (is_term_i[i]) begin
        if (open_d && !close_evt_o) begin
          close_evt_o = 1'b1;
          close_cnt_o = cnt_d;
        end
        open_d = 1'b0;
      end else if (is_data_i[i] && open_d) begin
        if (cnt_d != '1) cnt_d = cnt_d + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  // R9: an abort close only happens on a start code
  assert_abort_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    close_abort_o |-> (|is_start_i));

  // R10: a word with no boundary codes never closes a frame
  assert_no_close_without_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|is_start_i) && !(|is_term_i)) |-> !close_evt_o);

endmodule

// File: rtl/rxerr_classify.sv
module rxerr_classify #(
  parameter int CNT_W   = 11,
  parameter int PRE_LEN = 7,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  close_evt_i,
  input  logic                  close_abort_i,
  input  logic [CNT_W-1:0]      close_cnt_i,
  input  logic                  fcs_bad_i,
  output rxerr_pkg::err_pulse_t pulse_o
);
  import rxerr_pkg::*;

  int unsigned len_v;
  logic        bad_v;
  err_pulse_t  pulse_d, pulse_q;

  always_comb begin
    len_v   = payload_len(32'(close_cnt_i), PRE_LEN);
    bad_v   = close_abort_i || fcs_bad_i;
    pulse_d = close_evt_i ? classify(len_v, bad_v, MIN_LEN, MAX_LEN) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  // R11: size classes are exclusive
  assert_size_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pulse_q.runt, pulse_q.giant, pulse_q.sized}));

  // R11: every size strobe comes with the general strobe
  assert_size_implies_fcs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q.runt || pulse_q.giant || pulse_q.sized) |-> pulse_q.fcs);

  // R4: general strobe carries exactly one size class
  assert_fcs_has_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q.fcs |-> ($countones({pulse_q.runt, pulse_q.giant, pulse_q.sized}) == 1));

  // R4: a strobe only follows a close event
  assert_pulse_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt_i |=> !pulse_q.fcs);

endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats #(
  parameter int LANES   = 4,
  parameter int PRE_LEN = 7,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANES*8-1:0] rx_word,
  input  logic [LANES-1:0]   rx_ctrl,
  input  logic               rx_fcs_bad,
  output logic               inc_fcs_err,
  output logic               inc_runt,
  output logic               inc_giant,
  output logic               inc_sized_fcs_err
);
  import rxerr_pkg::*;

  // counter wide enough that saturation lies above the largest legal frame
  localparam int CNT_W = $clog2(MAX_LEN + PRE_LEN + 2);

  logic [LANES-1:0] is_data, is_start, is_term;
  logic             close_evt, close_abort;
  logic [CNT_W-1:0] close_cnt;
  err_pulse_t       pulse;

  rxerr_lane_decode #(.LANES(LANES)) i_decode (
    .word_i     (rx_word),
    .ctrl_i     (rx_ctrl),
    .is_data_o  (is_data),
    .is_start_o (is_start),
    .is_term_o  (is_term)
  );

  rxerr_frame_track #(.LANES(LANES), .CNT_W(CNT_W)) i_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_data_i     (is_data),
    .is_start_i    (is_start),
    .is_term_i     (is_term),
    .close_evt_o   (close_evt),
    .close_abort_o (close_abort),
    .close_cnt_o   (close_cnt)
  );

  rxerr_classify #(
    .CNT_W(CNT_W), .PRE_LEN(PRE_LEN), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) i_classify (
    .clk           (clk),
    .rst_n         (rst_n),
    .close_evt_i   (close_evt),
    .close_abort_i (close_abort),
    .close_cnt_i   (close_cnt),
    .fcs_bad_i     (rx_fcs_bad),
    .pulse_o       (pulse)
  );

  assign inc_fcs_err       = pulse.fcs;
  assign inc_runt          = pulse.runt;
  assign inc_giant         = pulse.giant;
  assign inc_sized_fcs_err = pulse.sized;

  // R8: a passing normal close is followed by no strobe
  assert_good_frame_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && !close_abort && !rx_fcs_bad) |=> !inc_fcs_err);

endmodule

// File: tb/test_rx_err_stats.sv
module test_rx_err_stats;
  localparam int LANES = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [LANES*8-1:0] rx_word;
  logic [LANES-1:0]   rx_ctrl;
  logic               rx_fcs_bad;
  logic               inc_fcs_err, inc_runt, inc_giant, inc_sized_fcs_err;

  always #2.5 clk = ~clk;   // 200 MHz

  rx_err_stats #(.LANES(LANES)) i_rx_err_stats (
    .clk, .rst_n, .rx_word, .rx_ctrl, .rx_fcs_bad,
    .inc_fcs_err, .inc_runt, .inc_giant, .inc_sized_fcs_err
  );

  int checks = 0;
  int fails  = 0;

  // byte stream: {bad_flag, ctrl, byte}
  logic [9:0]  bq[$];
  logic [3:0]  exp_q[$];   // {fcs, runt, giant, sized}
  string       tag_q[$];
  bit          mon_on = 1'b0;

  function automatic logic [3:0] expect_of(int len, bit bad);
    logic [3:0] e;
    e = 4'b0;
    if (bad) begin
      e[3] = 1'b1;
      if (len < 64)        e[2] = 1'b1;
      else if (len > 1518) e[1] = 1'b1;
      else                 e[0] = 1'b1;
    end
    return e;
  endfunction

  task automatic expect_item(int len, bit bad, string tag);
    logic [3:0] e;
    e = expect_of(len, bad);
    if (e != 4'b0) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
  endtask

  task automatic put(bit bad, bit ctl, logic [7:0] b);
    bq.push_back({bad, ctl, b});
  endtask

  task automatic idles(int n, bit bad = 1'b0);
    for (int i = 0; i < n; i++) put(bad, 1'b1, 8'h07);
  endtask

  // len counts bytes after the 7 preamble/delimiter bytes
  task automatic frame(int len, bit bad, bit closed, string tag);
    put(1'b0, 1'b1, 8'hFB);
    for (int i = 0; i < 6; i++) put(1'b0, 1'b0, 8'h55);
    put(1'b0, 1'b0, 8'hD5);
    for (int i = 0; i < len; i++) put(1'b0, 1'b0, 8'(i));
    if (closed) begin
      put(bad, 1'b1, 8'hFD);
      expect_item(len, bad, tag);
    end
  endtask

  task automatic flush();
    while (bq.size() != 0) begin
      logic [LANES*8-1:0] w;
      logic [LANES-1:0]   c;
      logic               fb;
      fb = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        logic [9:0] e;
        e = (bq.size() != 0) ? bq.pop_front() : {2'b01, 8'h07};
        w[l*8 +: 8] = e[7:0];
        c[l]        = e[8];
        fb          = fb | e[9];
      end
      @(posedge clk); #1;
      rx_word = w; rx_ctrl = c; rx_fcs_bad = fb;
    end
    @(posedge clk); #1;
    rx_word = {LANES{8'h07}}; rx_ctrl = '1; rx_fcs_bad = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic drained(string tag);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected strobes missing (actual %0d, expected 0)",
               tag, exp_q.size(), exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      logic [3:0] got;
      got = {inc_fcs_err, inc_runt, inc_giant, inc_sized_fcs_err};
      if (got != 4'b0) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R8/R10 unexpected strobe: actual %b expected 0000", got);
        end else begin
          logic [3:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (got != e) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", t, got, e);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rx_word = {LANES{8'h07}}; rx_ctrl = '1; rx_fcs_bad = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1 reset state
    if ({inc_fcs_err, inc_runt, inc_giant, inc_sized_fcs_err} != 4'b0) begin
      fails++;
      $display("FAIL R1: actual %b expected 0000",
               {inc_fcs_err, inc_runt, inc_giant, inc_sized_fcs_err});
    end
    @(posedge clk); #1 rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 / R10: terminate with nothing open, fcs flag on it
    put(1'b1, 1'b1, 8'hFD); idles(3);
    flush(); drained("R1 stray terminate");
    // R10: fcs flag on idle-only words
    idles(8, 1'b1);
    flush(); drained("R10 stray fcs flag");

    // R5 / R3 / R2: short failing frames at varied lane offsets
    frame(20, 1'b1, 1'b1, "R5 runt len 20");
    idles(1);
    frame(63, 1'b1, 1'b1, "R5 R3 runt len 63");
    idles(2);
    flush(); drained("R5");

    // R7 / R4 boundaries
    frame(64, 1'b1, 1'b1, "R7 R3 sized len 64");
    idles(3);
    frame(1518, 1'b1, 1'b1, "R7 sized len 1518");
    flush(); drained("R7");

    // R6 giants including saturation
    frame(1519, 1'b1, 1'b1, "R6 R3 giant len 1519");
    idles(1);
    frame(3000, 1'b1, 1'b1, "R6 R3 giant saturated len 3000");
    flush(); drained("R6");

    // R8 good frames of every class
    frame(30, 1'b0, 1'b1, "R8 good short");
    frame(500, 1'b0, 1'b1, "R8 good legal");
    frame(1600, 1'b0, 1'b1, "R8 good long");
    flush(); drained("R8");

    // R9: start while open aborts old frame as error by its length
    frame(80, 1'b1, 1'b0, "R9");
    expect_item(80, 1'b1, "R9 abort sized len 80");
    frame(70, 1'b0, 1'b1, "R9 restarted good frame");
    idles(2);
    frame(10, 1'b1, 1'b0, "R9");
    expect_item(10, 1'b1, "R9 abort runt len 10");
    frame(100, 1'b1, 1'b1, "R9 R4 restarted bad len 100");
    flush(); drained("R9");

    // R4: back-to-back failing frames each pulse once
    frame(64, 1'b1, 1'b1, "R4 back-to-back a");
    frame(65, 1'b1, 1'b1, "R4 back-to-back b");
    flush(); drained("R4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule